// File: doc/BRIEF.md
# Scaled-Offset Load/Store Data Unit

This unit sits between the register file and the data memory port of a 32-bit core. For one access it forms the effective address as a base register value plus an offset register value shifted left by zero to three places. It checks that the register numbers and access type form a legal combination and that the address is aligned for the access size. If the request is legal and aligned, it issues one memory request with little-endian byte enables and write data copied across the byte lanes.

For loads the unit records the destination register, size, signedness and low address bits. When the memory response arrives, it selects the addressed lane and zero- or sign-extends it to 32 bits. The result is presented one cycle later with a write-back enable. A word load into the program counter does not write back; it becomes a branch, or a fault if bit 0 of the loaded value is clear. Only one load may be in flight at a time.

Top module: `scaled_ls_unit`

## Requirements
- R1: `mem_addr` equals `req_base + (req_offset << req_shift)` for shift amounts 0 to 3, modulo 2^32.
- R2: Access size codes are 0 = byte, 1 = halfword, 2 = word. On a store (`req_is_load`=0), `mem_we` is 1. A byte store drives `mem_be` = 1 << addr[1:0] and the low byte of the store data copied into all four lanes. A halfword store drives `mem_be` = 4'b0011 when addr[1] is 0 and 4'b1100 when addr[1] is 1, with the low halfword copied into both halves. A word store drives 4'b1111 and the data unchanged.
- R3: An unsigned byte or halfword load returns the lane selected by the low address bits (little-endian: byte k is bits 8k+7..8k), zero-extended to 32 bits.
- R4: A signed byte or halfword load (`req_signed`=1) returns the same lane sign-extended to 32 bits.
- R5: A store with `req_signed`=1, or any access with size code 3, is illegal.
- R6: A base register of 15 (program counter) is illegal. An offset register of 13 (stack pointer) or 15 is also illegal.
- R7: A destination register of 13 is legal only for word accesses. A destination register of 15 is legal only for word loads.
- R8: An accepted illegal request issues no memory request. It pulses `err_illegal` for the one cycle after acceptance and does not raise `err_unaligned`, even if the address is also misaligned.
- R9: A legal halfword access with addr[0]=1, or a legal word access with addr[1:0]≠0, issues no memory request. It pulses `err_unaligned` for the one cycle after acceptance.
- R10: When a word load into register 15 returns data with bit 0 set, `br_valid` pulses with `br_target` equal to the data with bit 0 cleared, and `wb_en` stays low.
- R11: When a word load into register 15 returns data with bit 0 clear, `pc_fault` pulses and neither `br_valid` nor `wb_en` is raised.
- R12: For a load into any register other than 15, `wb_en`, `wb_rd` and `wb_data` are valid in the cycle after `mem_rsp_valid`.
- R13: While a load awaits its response, `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_is_load | input | 1 | 1 = load, 0 = store |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_signed | input | 1 | Sign-extend the loaded value |
| req_base | input | 32 | Base register value |
| req_offset | input | 32 | Offset register value |
| req_shift | input | 2 | Left shift applied to the offset |
| req_rt | input | 4 | Destination or source register number |
| req_rn | input | 4 | Base register number |
| req_rm | input | 4 | Offset register number |
| req_store_data | input | 32 | Store data |
| mem_req_valid | output | 1 | Memory request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_we | output | 1 | Write request |
| mem_addr | output | 32 | Effective byte address |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Lane-replicated write data |
| mem_rsp_valid | input | 1 | Load data returned |
| mem_rsp_rdata | input | 32 | Returned word |
| wb_en | output | 1 | Write-back of a load result |
| wb_rd | output | 4 | Write-back register number |
| wb_data | output | 32 | Extended load result |
| br_valid | output | 1 | Branch from a program-counter load |
| br_target | output | 32 | Halfword-aligned branch target |
| pc_fault | output | 1 | Program-counter load with bit 0 clear |
| err_illegal | output | 1 | Illegal register or type combination |
| err_unaligned | output | 1 | Misaligned access |

## Verification
The bench builds the unit with its default parameters: a 32-bit address and a 2-bit shift field, with the stack pointer and program counter at 13 and 15. The 2-bit shift field lets the bench reach the full scale of 8 and also wraparound at the top of the address space. With these register numbers, the bench can pit each forbidden register against every operand slot, and it can send a request that is both illegal and misaligned to check which error wins. Every byte lane is reached both as a load source and as a store target.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } acc_size_e;

   typedef struct packed {
      acc_size_e  size;
      logic       sgn;
      logic [1:0] lo;
      logic [3:0] rd;
   } load_ctx_t;
endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen #(
   parameter int AW      = 32,
   parameter int SHIFT_W = 2
) (
   input  logic [AW-1:0]      base,
   input  logic [AW-1:0]      offset,
   input  logic [SHIFT_W-1:0] shift,
   input  lsu_pkg::acc_size_e size,
   output logic [AW-1:0]      addr,
   output logic               misaligned
);
   import lsu_pkg::*;

   assign addr = base + (offset << shift);

   always_comb begin
      unique case (size)
         SZ_HALF: misaligned = addr[0];
         SZ_WORD: misaligned = |addr[1:0];
         default: misaligned = 1'b0;
      endcase
   end
endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes #(
   parameter int DW = 32
) (
   input  logic [DW-1:0]      data,
   input  logic [1:0]         lo,
   input  lsu_pkg::acc_size_e size,
   output logic [DW-1:0]      wdata,
   output logic [DW/8-1:0]    be
);
   import lsu_pkg::*;
   localparam int NB = DW / 8;

   always_comb begin
      unique case (size)
         SZ_BYTE: begin
            wdata = {NB{data[7:0]}};
            be    = NB'(1) << lo;
         end
         SZ_HALF: begin
            wdata = {(NB/2){data[15:0]}};
            be    = lo[1] ? NB'(4'b1100) : NB'(4'b0011);
         end
         default: begin
            wdata = data;
            be    = {NB{1'b1}};
         end
      endcase
   end
endmodule

// File: rtl/lsu_load_extend.sv
module lsu_load_extend #(
   parameter int DW = 32
) (
   input  logic [DW-1:0]      rdata,
   input  logic [1:0]         lo,
   input  lsu_pkg::acc_size_e size,
   input  logic               sgn,
   output logic [DW-1:0]      result
);
   import lsu_pkg::*;
   localparam int NB = DW / 8;

   logic [7:0]  lane_b [NB];
   logic [15:0] lane_h [NB/2];

   for (genvar g = 0; g < NB; g++) begin : g_byte
      assign lane_b[g] = rdata[8*g +: 8];
   end
   for (genvar g = 0; g < NB/2; g++) begin : g_half
      assign lane_h[g] = rdata[16*g +: 16];
   end

   logic [7:0]  sel_b;
   logic [15:0] sel_h;
   assign sel_b = lane_b[lo];
   assign sel_h = lane_h[lo[1]];

   always_comb begin
      unique case (size)
         SZ_BYTE: result = {{(DW-8){sgn & sel_b[7]}}, sel_b};
         SZ_HALF: result = {{(DW-16){sgn & sel_h[15]}}, sel_h};
         default: result = rdata;
      endcase
   end
endmodule

// File: rtl/scaled_ls_unit.sv
module scaled_ls_unit #(
   parameter int AW      = 32,
   parameter int DW      = 32,
   parameter int SHIFT_W = 2,
   parameter int REG_W   = 4,
   parameter int SP_IDX  = 13,
   parameter int PC_IDX  = 15
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic               req_is_load,
   input  logic [1:0]         req_size,
   input  logic               req_signed,
   input  logic [AW-1:0]      req_base,
   input  logic [AW-1:0]      req_offset,
   input  logic [SHIFT_W-1:0] req_shift,
   input  logic [REG_W-1:0]   req_rt,
   input  logic [REG_W-1:0]   req_rn,
   input  logic [REG_W-1:0]   req_rm,
   input  logic [DW-1:0]      req_store_data,
   output logic               mem_req_valid,
   input  logic               mem_req_ready,
   output logic               mem_we,
   output logic [AW-1:0]      mem_addr,
   output logic [DW/8-1:0]    mem_be,
   output logic [DW-1:0]      mem_wdata,
   input  logic               mem_rsp_valid,
   input  logic [DW-1:0]      mem_rsp_rdata,
   output logic               wb_en,
   output logic [REG_W-1:0]   wb_rd,
   output logic [DW-1:0]      wb_data,
   output logic               br_valid,
   output logic [DW-1:0]      br_target,
   output logic               pc_fault,
   output logic               err_illegal,
   output logic               err_unaligned
);
   import lsu_pkg::*;

   localparam logic [REG_W-1:0] SP = REG_W'(SP_IDX);
   localparam logic [REG_W-1:0] PC = REG_W'(PC_IDX);

   if (DW != 32) begin : g_chk_dw
      $error("scaled_ls_unit: DW must be 32");
   end
   if (AW < 2) begin : g_chk_aw
      $error("scaled_ls_unit: AW must be at least 2");
   end
   if (SP_IDX == PC_IDX || PC_IDX >= (1 << REG_W) || SP_IDX >= (1 << REG_W)) begin : g_chk_reg
      $error("scaled_ls_unit: bad special register indices");
   end

   acc_size_e size;
   assign size = acc_size_e'(req_size);

   logic misaligned;
   lsu_addr_gen #(.AW(AW), .SHIFT_W(SHIFT_W)) u_addr (
      .base(req_base), .offset(req_offset), .shift(req_shift),
      .size(size), .addr(mem_addr), .misaligned(misaligned)
   );

   lsu_store_lanes #(.DW(DW)) u_lanes (
      .data(req_store_data), .lo(mem_addr[1:0]), .size(size),
      .wdata(mem_wdata), .be(mem_be)
   );

   // legality of register and type combination
   logic illegal;
   always_comb begin
      illegal = 1'b0;
      if (size == SZ_RSVD)                         illegal = 1'b1;
      if (req_signed && !req_is_load)              illegal = 1'b1;
      if (req_rn == PC)                            illegal = 1'b1;
      if (req_rm == SP || req_rm == PC)            illegal = 1'b1;
      if (req_rt == SP && size != SZ_WORD)         illegal = 1'b1;
      if (req_rt == PC && !(req_is_load && size == SZ_WORD)) illegal = 1'b1;
   end

   logic      pend_q;
   load_ctx_t ctx_q;
   logic      good, accept;

   assign good          = !illegal && !misaligned;
   assign mem_req_valid = req_valid && good && !pend_q;
   assign mem_we        = !req_is_load;
   assign req_ready     = !pend_q && (!good || mem_req_ready);
   assign accept        = req_valid && req_ready;

   logic [DW-1:0] ext;
   lsu_load_extend #(.DW(DW)) u_ext (
      .rdata(mem_rsp_rdata), .lo(ctx_q.lo), .size(ctx_q.size),
      .sgn(ctx_q.sgn), .result(ext)
   );

   logic rsp_hit;
   assign rsp_hit = mem_rsp_valid && pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q        <= 1'b0;
         ctx_q         <= '0;
         err_illegal   <= 1'b0;
         err_unaligned <= 1'b0;
         wb_en         <= 1'b0;
         wb_rd         <= '0;
         wb_data       <= '0;
         br_valid      <= 1'b0;
         br_target     <= '0;
         pc_fault      <= 1'b0;
      end else begin
         err_illegal   <= accept && illegal;
         err_unaligned <= accept && !illegal && misaligned;
         if (accept && good && req_is_load) begin
            pend_q <= 1'b1;
            ctx_q  <= '{size: size, sgn: req_signed, lo: mem_addr[1:0], rd: req_rt};
         end else if (rsp_hit) begin
            pend_q <= 1'b0;
         end
         wb_en     <= rsp_hit && ctx_q.rd != PC;
         br_valid  <= rsp_hit && ctx_q.rd == PC && mem_rsp_rdata[0];
         pc_fault  <= rsp_hit && ctx_q.rd == PC && !mem_rsp_rdata[0];
         if (rsp_hit) begin
            wb_rd     <= ctx_q.rd;
            wb_data   <= ext;
            br_target <= {mem_rsp_rdata[DW-1:1], 1'b0};
         end
      end
   end

   p_busy_after_load_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_ready && !mem_we) |=> !req_ready);
   p_wb_follows_rsp_r12: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> $past(mem_rsp_valid));
   p_branch_aligned_r10: assert property (@(posedge clk) disable iff (!rst_n)
      br_valid |-> (!br_target[0] && !wb_en && !pc_fault));
   p_fault_no_issue_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (err_unaligned || err_illegal) |-> !$past(mem_req_valid));
   p_err_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(err_illegal && err_unaligned));
endmodule

// File: tb/tb_scaled_ls_unit.sv
module tb_scaled_ls_unit;
   logic        clk = 0, rst_n = 0;
   logic        req_valid = 0, req_ready, req_is_load = 0, req_signed = 0;
   logic [1:0]  req_size = 0, req_shift = 0;
   logic [31:0] req_base = 0, req_offset = 0, req_store_data = 0;
   logic [3:0]  req_rt = 0, req_rn = 0, req_rm = 0;
   logic        mem_req_valid, mem_we, mem_rsp_valid = 0;
   logic        mem_req_ready = 1;
   logic [31:0] mem_addr, mem_wdata, mem_rsp_rdata = 0, next_rdata = 0;
   logic [3:0]  mem_be;
   logic        wb_en, br_valid, pc_fault, err_illegal, err_unaligned;
   logic [3:0]  wb_rd;
   logic [31:0] wb_data, br_target;

   always #2 clk = ~clk;

   scaled_ls_unit dut (.*);

   // memory model: answers each accepted load on the next cycle
   always @(posedge clk) begin
      mem_rsp_valid <= mem_req_valid && mem_req_ready && !mem_we;
      mem_rsp_rdata <= next_rdata;
   end

   int total = 0, bad = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   typedef enum int {EV_WB, EV_BR, EV_PCF, EV_ILL, EV_UNAL} ev_e;
   typedef struct { ev_e kind; logic [31:0] val; logic [3:0] rd; string req; } item_t;
   item_t exp_q[$];

   // monitor
   always @(negedge clk) begin
      if (rst_n) begin
         int n;
         ev_e k;
         n = int'(wb_en) + int'(br_valid) + int'(pc_fault) + int'(err_illegal) + int'(err_unaligned);
         k = wb_en ? EV_WB : br_valid ? EV_BR : pc_fault ? EV_PCF : err_illegal ? EV_ILL : EV_UNAL;
         if (n > 1) chk(0, "R8 multiple events", 32'(n), 1);
         else if (n == 1) begin
            if (exp_q.size() == 0) chk(0, "unexpected event", 32'(k), 0);
            else begin
               item_t it;
               it = exp_q.pop_front();
               chk(k == it.kind, it.req, 32'(k), 32'(it.kind));
               if (k == EV_WB) begin
                  chk(wb_data == it.val, it.req, wb_data, it.val);
                  chk(wb_rd == it.rd, it.req, 32'(wb_rd), 32'(it.rd));
               end
               if (k == EV_BR) chk(br_target == it.val, it.req, br_target, it.val);
            end
         end
      end
   end

   function automatic logic [31:0] exp_load(logic [31:0] d, logic [1:0] lo, logic [1:0] sz, bit sg);
      logic [7:0] b; logic [15:0] h;
      b = d >> (8 * lo);
      h = d >> (16 * lo[1]);
      if (sz == 0) return sg ? {{24{b[7]}}, b} : {24'd0, b};
      if (sz == 1) return sg ? {{16{h[15]}}, h} : {16'd0, h};
      return d;
   endfunction

   task automatic do_req(input bit ld, input logic [1:0] sz, input bit sg,
                         input logic [31:0] b, input logic [31:0] o, input logic [1:0] sh,
                         input logic [3:0] rt, input logic [3:0] rn, input logic [3:0] rm,
                         input logic [31:0] sd, input logic [31:0] rd, input string tag);
      logic [31:0] a; bit ill, unal, iss;
      item_t it;
      a = b + (o << sh);
      ill = (sz == 3) || (sg && !ld) || rn == 15 || rm == 13 || rm == 15 ||
            (rt == 13 && sz != 2) || (rt == 15 && !(ld && sz == 2));
      unal = (sz == 1 && a[0]) || (sz == 2 && a[1:0] != 0);
      iss = !ill && !unal;
      @(negedge clk);
      req_valid = 1; req_is_load = ld; req_size = sz; req_signed = sg;
      req_base = b; req_offset = o; req_shift = sh;
      req_rt = rt; req_rn = rn; req_rm = rm; req_store_data = sd; next_rdata = rd;
      #1;
      chk(mem_req_valid == iss, {tag, " issue"}, 32'(mem_req_valid), 32'(iss));
      if (iss) chk(mem_addr == a, {"R1 ", tag}, mem_addr, a);
      if (iss && !ld) begin
         logic [31:0] ew; logic [3:0] eb;
         ew = sz == 0 ? {4{sd[7:0]}} : sz == 1 ? {2{sd[15:0]}} : sd;
         eb = sz == 0 ? 4'b0001 << a[1:0] : sz == 1 ? (a[1] ? 4'b1100 : 4'b0011) : 4'b1111;
         chk(mem_we == 1, {"R2 we ", tag}, 32'(mem_we), 1);
         chk(mem_wdata == ew, {"R2 wdata ", tag}, mem_wdata, ew);
         chk(mem_be == eb, {"R2 be ", tag}, 32'(mem_be), 32'(eb));
      end
      it.req = tag; it.rd = rt; it.val = 0;
      if (ill) begin it.kind = EV_ILL; exp_q.push_back(it); end
      else if (unal) begin it.kind = EV_UNAL; exp_q.push_back(it); end
      else if (ld) begin
         if (rt == 15) begin
            it.kind = rd[0] ? EV_BR : EV_PCF;
            it.val = {rd[31:1], 1'b0};
         end else begin
            it.kind = EV_WB;
            it.val = exp_load(rd, a[1:0], sz, sg);
         end
         exp_q.push_back(it);
      end
      @(posedge clk);
      @(negedge clk);
      req_valid = 0;
      if (iss && ld) chk(req_ready == 0, {"R13 ", tag}, 32'(req_ready), 0);
      repeat (3) @(negedge clk);
   endtask

   bit done = 0;
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         chk(0, "watchdog", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(req_ready == 1, "reset ready", 32'(req_ready), 1);
      chk(!wb_en && !br_valid && !pc_fault && !err_illegal && !err_unaligned && !mem_req_valid,
          "reset outputs", 0, 0);
      // R12 word load, R1 scale 4
      do_req(1, 2, 0, 32'h1000, 32'h4, 2, 4'd2, 4'd1, 4'd3, 0, 32'hDEADBEEF, "R12 word load");
      do_req(1, 2, 0, 32'h3000, 32'h1, 3, 4'd13, 4'd1, 4'd3, 0, 32'h0BADF00D, "R1 shift3 sp load");
      do_req(1, 2, 0, 32'hFFFFFFF0, 32'h8, 1, 4'd0, 4'd1, 4'd3, 0, 32'h11112222, "R1 wrap");
      // R3 / R4 extension
      do_req(1, 0, 0, 32'h2000, 32'h3, 0, 4'd4, 4'd1, 4'd3, 0, 32'h80112233, "R3 ubyte lane3");
      do_req(1, 0, 1, 32'h2000, 32'h3, 0, 4'd4, 4'd1, 4'd3, 0, 32'h80112233, "R4 sbyte lane3");
      do_req(1, 0, 1, 32'h2000, 32'h1, 0, 4'd4, 4'd1, 4'd3, 0, 32'h80117F33, "R4 sbyte positive");
      do_req(1, 1, 0, 32'h2002, 32'h0, 0, 4'd5, 4'd1, 4'd3, 0, 32'hF00D1234, "R3 uhalf upper");
      do_req(1, 1, 1, 32'h2000, 32'h0, 0, 4'd5, 4'd1, 4'd3, 0, 32'h00008001, "R4 shalf lower");
      // R2 stores
      do_req(0, 0, 0, 32'h4000, 32'h1, 0, 4'd6, 4'd1, 4'd3, 32'h123456AB, 0, "R2 byte lane1");
      do_req(0, 0, 0, 32'h4000, 32'h3, 0, 4'd6, 4'd1, 4'd3, 32'h123456CD, 0, "R2 byte lane3");
      do_req(0, 1, 0, 32'h4000, 32'h1, 1, 4'd6, 4'd1, 4'd3, 32'h0000BEEF, 0, "R2 half upper");
      do_req(0, 2, 0, 32'h4000, 32'h2, 1, 4'd13, 4'd1, 4'd3, 32'hCAFEF00D, 0, "R2 word sp store");
      // R5 / R6 / R7 illegal combinations
      do_req(0, 0, 1, 32'h4000, 0, 0, 4'd1, 4'd2, 4'd3, 32'h1, 0, "R5 signed store");
      do_req(1, 3, 0, 32'h4000, 0, 0, 4'd1, 4'd2, 4'd3, 0, 0, "R5 reserved size");
      do_req(1, 2, 0, 32'h4000, 0, 0, 4'd1, 4'd15, 4'd3, 0, 0, "R6 base pc");
      do_req(1, 2, 0, 32'h4000, 0, 0, 4'd1, 4'd2, 4'd13, 0, 0, "R6 offset sp");
      do_req(0, 2, 0, 32'h4000, 0, 0, 4'd1, 4'd2, 4'd15, 0, 0, "R6 offset pc");
      do_req(1, 0, 0, 32'h4000, 0, 0, 4'd13, 4'd2, 4'd3, 0, 0, "R7 sp byte");
      do_req(0, 2, 0, 32'h4000, 0, 0, 4'd15, 4'd2, 4'd3, 0, 0, "R7 pc store");
      do_req(1, 1, 0, 32'h4000, 0, 0, 4'd15, 4'd2, 4'd3, 0, 0, "R7 pc half load");
      // R9 alignment, R8 priority
      do_req(1, 1, 0, 32'h4001, 0, 0, 4'd1, 4'd2, 4'd3, 0, 0, "R9 half odd");
      do_req(0, 2, 0, 32'h4000, 32'h1, 1, 4'd1, 4'd2, 4'd3, 0, 0, "R9 word lo2");
      do_req(0, 1, 1, 32'h4001, 0, 0, 4'd1, 4'd2, 4'd3, 0, 0, "R8 illegal over unaligned");
      // R10 / R11 program counter loads
      do_req(1, 2, 0, 32'h5000, 32'h4, 0, 4'd15, 4'd2, 4'd3, 0, 32'h00008001, "R10 pc branch");
      do_req(1, 2, 0, 32'h5000, 32'h8, 0, 4'd15, 4'd2, 4'd3, 0, 32'h00008000, "R11 pc fault");
      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "missing events", 32'(exp_q.size()), 0);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule